// File: doc/BRIEF.md
# Streaming CRC-32 Engine with Input Byte and Bit Conditioning

This block computes a running CRC-32 over a stream of data writes. Each write delivers either a whole 32-bit word or a single byte. A control write sets the width, and the width can change between any two data writes without restarting the calculation. Before a word reaches the division logic, a reorder stage can swap the bytes within each half-word, swap the two half-words, or do both. A second stage can then mirror the bit order inside every byte.

The same control write can also reseed the remainder to all zeros or all ones. It can instead leave the remainder as it is, so that a long computation carries on across changes of configuration. Every data write is absorbed in one clock. The raw remainder and a post-processed result, which is its bitwise complement, are both available as outputs at all times.

Top module: `crc_cond_engine`

## Requirements
- R1: A control write whose init code is 2 loads the remainder with 0x00000000 on the next clock. Init code 3 loads it with 0xFFFFFFFF on the next clock.
- R2: A control write whose init code is 0 or 1 leaves the remainder unchanged. It still updates the width, reorder and bit-mirror settings.
- R3: The size bit selects the width of each data write: 0 means a 32-bit word and 1 means one byte. The width may change between writes with no reseed, and the stream stays continuous.
- R4: The 2-bit reorder code acts on the word {B3,B2,B1,B0}, where B0 is bits 7:0. Code 0 leaves it unchanged. Code 1 gives {B2,B3,B0,B1}. Code 2 gives {B1,B0,B3,B2}. Code 3 gives {B0,B1,B2,B3}.
- R5: When the bit-mirror bit is 1, the bits inside each byte are reversed after the reorder stage. Bit i of a byte moves to bit 7-i.
- R6: In byte mode only data bits 7:0 are used and the reorder code has no effect. The bit-mirror setting still applies to that byte.
- R7: The result output always equals the bitwise complement of the remainder output.
- R8: A control write and a data write in the same cycle use the new settings. If that control write reseeds, the data write starts from the new seed.
- R9: The update uses polynomial 0x04C11DB7, most significant bit first, and takes one clock per write. Feeding the ASCII bytes "123456789" in byte mode from an all-ones seed, with no bit mirror, leaves a remainder of 0x0376E6E7.
- R10: After reset the remainder is 0xFFFFFFFF, the width is word, the reorder code is 0 and the bit mirror is off.
- R11: In a cycle with neither a data write nor a reseeding control write, the remainder holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_init | input | 2 | Init code: 0/1 keep, 2 zeros, 3 ones |
| ctrl_size | input | 1 | 0 word writes, 1 byte writes |
| ctrl_endian | input | 2 | Byte/half-word reorder code |
| ctrl_bitrev | input | 1 | Mirror bits within each byte |
| data_we | input | 1 | Data write strobe |
| data_in | input | 32 | Data word, or a byte in bits 7:0 |
| remainder_o | output | 32 | Raw running remainder |
| result_o | output | 32 | Post-processed (complemented) result |

## Verification
The hardest case to reach is a control write and a data write in the same cycle. In that cycle the old and new settings and seeds compete, and a reseed has to be overridden by the data update while still feeding it. The bench drives both strobes on the same falling edge, with a new seed, byte width and bit mirror. It then compares the result against the expected value computed from the new seed alone. The bench also sweeps every reorder code and bit-mirror combination in both widths, and interleaves width changes with no reseed in between. Each remainder is compared with a CRC that the bench computes from its own byte-index arithmetic.

// File: rtl/crc_cond_pkg.sv
package crc_cond_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int NBYTES = WORD_W / BYTE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ORD_KEEP    = 2'd0,
        ORD_SWAP_B  = 2'd1,
        ORD_SWAP_H  = 2'd2,
        ORD_SWAP_BH = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        SEED_KEEP0 = 2'd0,
        SEED_KEEP1 = 2'd1,
        SEED_ZERO  = 2'd2,
        SEED_ONES  = 2'd3
    } seed_e;

    typedef enum logic {
        WIDTH_WORD = 1'b0,
        WIDTH_BYTE = 1'b1
    } width_e;

    typedef struct packed {
        width_e width;
        order_e order;
        logic   mirror;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{width: WIDTH_WORD, order: ORD_KEEP, mirror: 1'b0};

    function automatic word_t reorder(word_t w, order_e m);
        word_t r;
        case (m)
            ORD_SWAP_B:  r = {w[23:16], w[31:24], w[7:0], w[15:8]};
            ORD_SWAP_H:  r = {w[15:0], w[31:16]};
            ORD_SWAP_BH: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            default:     r = w;
        endcase
        return r;
    endfunction

    function automatic byte_t flip_byte(byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic word_t crc_word(word_t crc, word_t d, word_t poly);
        word_t c = crc;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (c[WORD_W-1] ^ d[i]) c = {c[WORD_W-2:0], 1'b0} ^ poly;
            else                   c = {c[WORD_W-2:0], 1'b0};
        end
        return c;
    endfunction

    function automatic word_t crc_byte(word_t crc, byte_t d, word_t poly);
        word_t c = crc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (c[WORD_W-1] ^ d[i]) c = {c[WORD_W-2:0], 1'b0} ^ poly;
            else                   c = {c[WORD_W-2:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_cond_ctrl.sv
module crc_cond_ctrl
    import crc_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  seed_e init_code,
    input  cfg_t  cfg_new,
    output cfg_t  cfg_eff,
    output logic  reseed,
    output word_t seed
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= CFG_RESET;
        else if (we) cfg_q <= cfg_new;
    end

    always_comb begin
        cfg_eff = we ? cfg_new : cfg_q;
        reseed  = we && (init_code == SEED_ZERO || init_code == SEED_ONES);
        seed    = (init_code == SEED_ONES) ? '1 : '0;
    end
endmodule

// File: rtl/crc_cond_shaper.sv
module crc_cond_shaper
    import crc_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  word_t din,
    output word_t dout
);
    word_t ordered;
    word_t flipped;

    always_comb begin
        if (cfg.width == WIDTH_BYTE)
            ordered = {{(WORD_W-BYTE_W){1'b0}}, din[BYTE_W-1:0]};
        else
            ordered = reorder(din, cfg.order);
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign flipped[g*BYTE_W +: BYTE_W] = flip_byte(ordered[g*BYTE_W +: BYTE_W]);
    end

    assign dout = cfg.mirror ? flipped : ordered;

    // R4
    weight_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.width == WIDTH_WORD) |-> ($countones(dout) == $countones(din)));

    // R6
    byte_weight_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.width == WIDTH_BYTE) |-> ($countones(dout) == $countones(din[BYTE_W-1:0])));
endmodule

// File: rtl/crc_cond_update.sv
module crc_cond_update
    import crc_cond_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  width_e width,
    input  word_t  base,
    input  word_t  data,
    output word_t  next
);
    always_comb begin
        if (width == WIDTH_BYTE) next = crc_byte(base, data[BYTE_W-1:0], POLY);
        else                     next = crc_word(base, data, POLY);
    end
endmodule

// File: rtl/crc_cond_engine.sv
module crc_cond_engine
    import crc_cond_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic [1:0]  ctrl_init,
    input  logic        ctrl_size,
    input  logic [1:0]  ctrl_endian,
    input  logic        ctrl_bitrev,
    input  logic        data_we,
    input  logic [31:0] data_in,
    output logic [31:0] remainder_o,
    output logic [31:0] result_o
);
    cfg_t  cfg_new;
    cfg_t  cfg_eff;
    logic  reseed;
    word_t seed;
    word_t shaped;
    word_t base;
    word_t updated;
    word_t rem_q;

    assign cfg_new = '{width: width_e'(ctrl_size), order: order_e'(ctrl_endian),
                       mirror: ctrl_bitrev};

    crc_cond_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .we        (ctrl_we),
        .init_code (seed_e'(ctrl_init)),
        .cfg_new   (cfg_new),
        .cfg_eff   (cfg_eff),
        .reseed    (reseed),
        .seed      (seed)
    );

    crc_cond_shaper u_shaper (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg_eff),
        .din  (data_in),
        .dout (shaped)
    );

    assign base = reseed ? seed : rem_q;

    crc_cond_update #(.POLY(POLY)) u_update (
        .width (cfg_eff.width),
        .base  (base),
        .data  (shaped),
        .next  (updated)
    );

    always_ff @(posedge clk) begin
        if (rst)          rem_q <= '1;
        else if (data_we) rem_q <= updated;
        else              rem_q <= base;
    end

    assign remainder_o = rem_q;
    assign result_o    = ~rem_q;

    // R1
    reseed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_init == 2'd2 && !data_we) |=> (remainder_o == 32'h0));

    // R1
    reseed_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_init == 2'd3 && !data_we) |=> (remainder_o == 32'hFFFFFFFF));

    // R2
    keep_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ctrl_init[1] && !data_we) |=> $stable(remainder_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_we && !data_we) |=> $stable(remainder_o));
endmodule

// File: tb/crc_cond_engine_bench.sv
module crc_cond_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [1:0]  ctrl_init = 2'd0;
    logic        ctrl_size = 1'b0;
    logic [1:0]  ctrl_endian = 2'd0;
    logic        ctrl_bitrev = 1'b0;
    logic        data_we = 1'b0;
    logic [31:0] data_in = 32'h0;
    logic [31:0] remainder_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_rem;
    logic        m_size;
    logic [1:0]  m_end;
    logic        m_br;

    localparam logic [31:0] P = 32'h04C11DB7;

    always #5 clk = ~clk;

    crc_cond_engine u_crc_cond_engine (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_init(ctrl_init),
        .ctrl_size(ctrl_size), .ctrl_endian(ctrl_endian), .ctrl_bitrev(ctrl_bitrev),
        .data_we(data_we), .data_in(data_in),
        .remainder_o(remainder_o), .result_o(result_o)
    );

    function automatic logic [31:0] ref_cond(logic [31:0] d, logic sz, logic [1:0] e, logic br);
        logic [31:0] v = '0;
        logic [31:0] r = '0;
        if (sz) v[7:0] = d[7:0];
        else
            for (int k = 0; k < 4; k++) v[8*k +: 8] = d[8*(k ^ int'(e)) +: 8];
        if (br) begin
            for (int i = 0; i < 32; i++) r[(i & ~7) | (7 - (i & 7))] = v[i];
            v = r;
        end
        return v;
    endfunction

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] v, int nbits);
        logic [31:0] x = c;
        for (int i = nbits - 1; i >= 0; i--)
            x = {x[30:0], 1'b0} ^ (((x[31] ^ v[i]) != 1'b0) ? P : 32'h0);
        return x;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_ctrl(logic [1:0] init, logic sz, logic [1:0] e, logic br);
        if (init == 2'd2) m_rem = 32'h0;
        if (init == 2'd3) m_rem = 32'hFFFFFFFF;
        m_size = sz; m_end = e; m_br = br;
    endtask

    task automatic model_data(logic [31:0] d);
        m_rem = ref_crc(m_rem, ref_cond(d, m_size, m_end, m_br), m_size ? 8 : 32);
    endtask

    task automatic ctrl_write(logic [1:0] init, logic sz, logic [1:0] e, logic br);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_init = init; ctrl_size = sz; ctrl_endian = e; ctrl_bitrev = br;
        @(negedge clk);
        ctrl_we = 1'b0;
        model_ctrl(init, sz, e, br);
    endtask

    task automatic data_write(logic [31:0] d, string tag);
        @(negedge clk);
        data_we = 1'b1; data_in = d;
        @(negedge clk);
        data_we = 1'b0;
        model_data(d);
        chk(tag, remainder_o, m_rem);
        chk("R7", result_o, ~m_rem);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        logic [31:0] held;
        byte unsigned ascii [9];
        pats[0] = 32'h12345678; pats[1] = 32'h80000001; pats[2] = 32'hA5C30F1E;
        pats[3] = 32'hFFFFFFFF; pats[4] = 32'h00000001; pats[5] = 32'h9E3779B9;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", remainder_o, 32'hFFFFFFFF);
        chk("R7", result_o, 32'h00000000);
        m_rem = 32'hFFFFFFFF; m_size = 1'b0; m_end = 2'd0; m_br = 1'b0;
        data_write(32'h12345678, "R10");

        // R1 seeds
        ctrl_write(2'd2, 1'b0, 2'd0, 1'b0);
        chk("R1", remainder_o, 32'h00000000);
        ctrl_write(2'd3, 1'b0, 2'd0, 1'b0);
        chk("R1", remainder_o, 32'hFFFFFFFF);

        // R2 keep codes
        data_write(32'hCAFEF00D, "R9");
        held = remainder_o;
        ctrl_write(2'd0, 1'b0, 2'd2, 1'b1);
        chk("R2", remainder_o, held);
        ctrl_write(2'd1, 1'b0, 2'd1, 1'b0);
        chk("R2", remainder_o, held);
        data_write(32'h0F0F1234, "R2");

        // R11 idle hold
        held = remainder_o;
        repeat (4) @(negedge clk);
        chk("R11", remainder_o, held);

        // R4 / R5 word sweep
        for (int e = 0; e < 4; e++)
            for (int br = 0; br < 2; br++) begin
                ctrl_write(2'd2, 1'b0, 2'(e), 1'(br));
                for (int k = 0; k < 6; k++)
                    data_write(pats[k], br != 0 ? "R5" : "R4");
            end

        // R6 byte sweep: reorder must not matter
        for (int e = 0; e < 4; e++)
            for (int br = 0; br < 2; br++) begin
                ctrl_write(2'd3, 1'b1, 2'(e), 1'(br));
                for (int b = 0; b < 256; b += 37)
                    data_write(32'hDEADBE00 | 32'(b), "R6");
            end

        // R3 width switching without reseed
        ctrl_write(2'd3, 1'b0, 2'd1, 1'b0);
        data_write(32'h01020304, "R3");
        ctrl_write(2'd0, 1'b1, 2'd1, 1'b1);
        data_write(32'hAABBCC5A, "R3");
        ctrl_write(2'd1, 1'b0, 2'd3, 1'b1);
        data_write(32'h11223344, "R3");
        ctrl_write(2'd0, 1'b1, 2'd0, 1'b0);
        data_write(32'h000000C3, "R3");

        // R8 control and data in the same cycle
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_init = 2'd2; ctrl_size = 1'b1; ctrl_endian = 2'd3; ctrl_bitrev = 1'b1;
        data_we = 1'b1; data_in = 32'h11223344;
        @(negedge clk);
        ctrl_we = 1'b0; data_we = 1'b0;
        model_ctrl(2'd2, 1'b1, 2'd3, 1'b1);
        model_data(32'h11223344);
        chk("R8", remainder_o, m_rem);
        chk("R8", remainder_o, ref_crc(32'h0, 32'h00000022, 8));

        // R9 known check value
        ascii = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        ctrl_write(2'd3, 1'b1, 2'd0, 1'b0);
        for (int i = 0; i < 9; i++) data_write(32'(ascii[i]), "R9");
        chk("R9", remainder_o, 32'h0376E6E7);
        chk("R7", result_o, 32'hFC891918);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule